// File: doc/BRIEF.md
# Boot ROM Overlay Memory Decoder

This block sits between a small byte-wide audio processor and a 64 KiB synchronous RAM. Every processor access passes through it. A 64-byte boot program sits over the highest 64 addresses (0xFFC0 to 0xFFFF), so a processor that starts at 0xFFC0 runs the boot code out of reset. Software hands that window back to RAM by setting bit 7 of the control byte at 0x00F1, and can take it back by clearing the bit. While the boot image covers the window, stores into it are discarded. Stores to 0x00F1 reach RAM like any other low address. The block keeps its own copy of the control bit, so it never has to read RAM to decide where a fetch goes.

A byte read returns data one cycle after its strobe. A word read (the read strobe together with the wide qualifier) runs as two back-to-back byte fetches, at the address and then at the address plus one, modulo 65536. The result comes back little-endian, two cycles after the strobe. During the cycle of the second fetch the block raises a busy flag and ignores both strobes. If both strobes are raised together, the read is taken and the write is dropped.

Top module: `bootrom_overlay`

## Requirements
- R1: A byte read of any address below 0xFFC0 sets `cpu_rvalid` exactly one cycle after the strobe cycle. In that cycle it returns the RAM byte in `cpu_rdata[7:0]`, with `cpu_rdata[15:8]` = 0.
- R2: While the overlay is mapped, a byte read of 0xFFC0+n (n = 0..63) returns boot image byte n. The image opens with CD EF BD E8 00 C6 1D D0 and closes with 1F 00 00 C0 FF.
- R3: Writing a byte with bit 7 set to 0x00F1 unmaps the overlay, after which window reads return RAM data. Writing a byte with bit 7 clear maps it again.
- R4: A write below 0xFFC0 always raises `ram_we` in its own cycle with `ram_addr` equal to the write address, and a later read returns the written byte.
- R5: While the overlay is mapped, writes into the window do not raise `ram_we` and leave RAM unchanged. While it is unmapped, they update RAM.
- R6: After reset the overlay is mapped, and `cpu_rvalid` and `cpu_busy` are 0.
- R7: A word read raises `cpu_busy` in the next cycle, with `cpu_rvalid` low and a RAM read issued at address+1. In the cycle after that it raises `cpu_rvalid`, with byte(addr) in `cpu_rdata[7:0]` and byte(addr+1) in `cpu_rdata[15:8]`.
- R8: The second fetch of a word read at 0xFFFF goes to 0x0000.
- R9: Each byte of a word read is decoded on its own. A word read at 0xFFBF while mapped returns the RAM byte at 0xFFBF as the low half and 0xCD as the high half.
- R10: The control byte at 0x00F1 is ordinary RAM: a value written there reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | Processor byte address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wide | input | 1 | With `cpu_rd`, requests a 16-bit little-endian read |
| cpu_rdata | output | 16 | Read result; upper byte is zero for byte reads |
| cpu_rvalid | output | 1 | Read result present this cycle |
| cpu_busy | output | 1 | Second fetch of a word read owns the RAM port; strobes are ignored |
| ram_addr | output | 16 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write enable |
| ram_re | output | 1 | RAM read enable |
| ram_rdata | input | 8 | RAM read data, one cycle after `ram_re` |

## Verification
The write gate acts in the strobe cycle, so `ram_we` is sampled on the falling edge of that same cycle. A byte read's data and valid are due one cycle after the strobe. A word read has busy due at one cycle and the combined result at two. The bench raises each strobe on a falling edge and samples at the falling edge that lands in the cycle where the result is due, so no check races the edge that produces the value. The effect of a mapping change shows up at the first read issued after the write to 0x00F1, and the sweeps issue that read only after the write has completed.

// File: rtl/bootrom_pkg.sv
package bootrom_pkg;

    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int ROM_AW    = 6;
    localparam int ROM_DEPTH = 1 << ROM_AW;

    // Lowest address covered by the overlay window
    localparam logic [ADDR_W-1:0] WIN_BASE = {ADDR_W{1'b1}} << ROM_AW;

    // Boot program, byte n sits at WIN_BASE + n
    localparam logic [DATA_W-1:0] BOOT_IMAGE [ROM_DEPTH] = '{
        8'hCD, 8'hEF, 8'hBD, 8'hE8, 8'h00, 8'hC6, 8'h1D, 8'hD0,
        8'hFC, 8'h8F, 8'hAA, 8'hF4, 8'h8F, 8'hBB, 8'hF5, 8'h78,
        8'hCC, 8'hF4, 8'hD0, 8'hFB, 8'h2F, 8'h19, 8'hEB, 8'hF4,
        8'hD0, 8'hFC, 8'h7E, 8'hF4, 8'hD0, 8'h0B, 8'hE4, 8'hF5,
        8'hCB, 8'hF4, 8'hD7, 8'h00, 8'hFC, 8'hD0, 8'hF3, 8'hAB,
        8'h01, 8'h10, 8'hEF, 8'h7E, 8'hF4, 8'h10, 8'hEB, 8'hBA,
        8'hF6, 8'hDA, 8'h00, 8'hBA, 8'hF4, 8'hC4, 8'hF4, 8'hDD,
        8'h5D, 8'hD0, 8'hDB, 8'h1F, 8'h00, 8'h00, 8'hC0, 8'hFF
    };

    // What the fetch issued in the previous cycle was for
    typedef enum logic [1:0] {
        FETCH_NONE = 2'd0,
        FETCH_BYTE = 2'd1,
        FETCH_LO   = 2'd2,
        FETCH_HI   = 2'd3
    } fetch_kind_e;

    typedef struct packed {
        logic                unmap;      // mirror of control bit, 1 = window is RAM
        fetch_kind_e         kind;       // fetch in flight
        logic                rom_hit;    // fetch in flight is served by the image
        logic [ROM_AW-1:0]   off;        // image offset of fetch in flight
        logic                need_hi;    // second byte of a word read due now
        logic [ADDR_W-1:0]   next_addr;  // address of that second byte
        logic [DATA_W-1:0]   lo;         // captured low byte of a word read
    } ovl_state_t;

endpackage

// File: rtl/ovl_window_decode.sv
module ovl_window_decode
    import bootrom_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [ROM_AW-1:0] off
);
    // The window is the top ROM_DEPTH addresses: all upper bits set
    always_comb begin
        hit = &addr[ADDR_W-1:ROM_AW];
        off = addr[ROM_AW-1:0];
    end
endmodule

// File: rtl/ovl_boot_rom.sv
module ovl_boot_rom
    import bootrom_pkg::*;
(
    input  logic [ROM_AW-1:0] off,
    output logic [DATA_W-1:0] data
);
    always_comb begin
        data = BOOT_IMAGE[off];
    end
endmodule

// File: rtl/bootrom_overlay.sv
module bootrom_overlay
    import bootrom_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h00F1,
    parameter int                CTRL_BIT  = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic [DATA_W-1:0]   cpu_wdata,
    input  logic                cpu_rd,
    input  logic                cpu_wr,
    input  logic                cpu_wide,
    output logic [2*DATA_W-1:0] cpu_rdata,
    output logic                cpu_rvalid,
    output logic                cpu_busy,
    output logic [ADDR_W-1:0]   ram_addr,
    output logic [DATA_W-1:0]   ram_wdata,
    output logic                ram_we,
    output logic                ram_re,
    input  logic [DATA_W-1:0]   ram_rdata
);
    ovl_state_t s_q, s_d;

    logic              issue_hi;
    logic              acc_rd;
    logic              acc_wr;
    logic              win_hit;
    logic [ROM_AW-1:0] win_off;
    logic [DATA_W-1:0] rom_byte;
    logic [DATA_W-1:0] fetched;

    // Decode the address that actually goes to the RAM port this cycle
    ovl_window_decode u_decode (
        .addr (ram_addr),
        .hit  (win_hit),
        .off  (win_off)
    );

    // Image lookup uses the offset registered with the fetch in flight
    ovl_boot_rom u_rom (
        .off  (s_q.off),
        .data (rom_byte)
    );

    always_comb begin
        // Port steering
        issue_hi  = s_q.need_hi;
        acc_rd    = cpu_rd && !issue_hi;
        acc_wr    = cpu_wr && !cpu_rd && !issue_hi;
        ram_addr  = issue_hi ? s_q.next_addr : cpu_addr;
        ram_re    = issue_hi || acc_rd;
        ram_we    = acc_wr && (!win_hit || s_q.unmap);
        ram_wdata = cpu_wdata;
        cpu_busy  = issue_hi;

        // Return path, steered by registered range and mapping
        fetched    = s_q.rom_hit ? rom_byte : ram_rdata;
        cpu_rvalid = (s_q.kind == FETCH_BYTE) || (s_q.kind == FETCH_HI);
        cpu_rdata  = (s_q.kind == FETCH_HI) ? {fetched, s_q.lo}
                                            : {{DATA_W{1'b0}}, fetched};

        // Next state
        s_d         = s_q;
        s_d.kind    = FETCH_NONE;
        s_d.need_hi = 1'b0;

        if (s_q.kind == FETCH_LO) begin
            s_d.lo = fetched;
        end

        if (ram_re) begin
            s_d.rom_hit = win_hit && !s_q.unmap;
            s_d.off     = win_off;
            if (issue_hi) begin
                s_d.kind = FETCH_HI;
            end else if (cpu_wide) begin
                s_d.kind = FETCH_LO;
            end else begin
                s_d.kind = FETCH_BYTE;
            end
        end

        if (acc_rd && cpu_wide) begin
            s_d.need_hi   = 1'b1;
            s_d.next_addr = cpu_addr + ADDR_W'(1);
        end

        if (acc_wr && (cpu_addr == CTRL_ADDR)) begin
            s_d.unmap = cpu_wdata[CTRL_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/bootrom_overlay_chk.sv
module bootrom_overlay_chk
    import bootrom_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic              cpu_wide,
    input logic              cpu_rvalid,
    input logic              cpu_busy,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              ram_we,
    input logic              ram_re
);
    // Independent shadow of the control bit, built from port traffic only
    logic shadow_unmap;
    logic wr_taken;

    assign wr_taken = cpu_wr && !cpu_rd && !cpu_busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_unmap <= 1'b0;
        end else if (wr_taken && (cpu_addr == 16'h00F1)) begin
            shadow_unmap <= cpu_wdata[7];
        end
    end

    p_byte_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_wide && !cpu_busy) |=> (cpu_rvalid && !cpu_busy));

    p_low_write_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_taken && (cpu_addr < WIN_BASE)) |-> (ram_we && (ram_addr == cpu_addr)));

    p_window_write_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && (ram_addr >= WIN_BASE)) |-> shadow_unmap);

    p_word_second_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_wide && !cpu_busy) |=> (cpu_busy && ram_re && !cpu_rvalid && !ram_we));

    p_word_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_busy |=> (cpu_rvalid && !cpu_busy));

    p_word_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_busy |-> (ram_addr == ($past(cpu_addr) + ADDR_W'(1))));

endmodule

bind bootrom_overlay bootrom_overlay_chk i_chk (.*);

// File: tb/test_bootrom_overlay.sv
module test_bootrom_overlay;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic        cpu_wide = 1'b0;
    logic [15:0] cpu_rdata;
    logic        cpu_rvalid;
    logic        cpu_busy;
    logic [15:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic        ram_we;
    logic        ram_re;
    logic [7:0]  ram_rdata = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    bootrom_overlay i_bootrom_overlay (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wide(cpu_wide),
        .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid), .cpu_busy(cpu_busy),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
        .ram_re(ram_re), .ram_rdata(ram_rdata)
    );

    // Expected boot image, byte n at 0xFFC0+n
    localparam logic [7:0] IMG [64] = '{
        8'hCD, 8'hEF, 8'hBD, 8'hE8, 8'h00, 8'hC6, 8'h1D, 8'hD0,
        8'hFC, 8'h8F, 8'hAA, 8'hF4, 8'h8F, 8'hBB, 8'hF5, 8'h78,
        8'hCC, 8'hF4, 8'hD0, 8'hFB, 8'h2F, 8'h19, 8'hEB, 8'hF4,
        8'hD0, 8'hFC, 8'h7E, 8'hF4, 8'hD0, 8'h0B, 8'hE4, 8'hF5,
        8'hCB, 8'hF4, 8'hD7, 8'h00, 8'hFC, 8'hD0, 8'hF3, 8'hAB,
        8'h01, 8'h10, 8'hEF, 8'h7E, 8'hF4, 8'h10, 8'hEB, 8'hBA,
        8'hF6, 8'hDA, 8'h00, 8'hBA, 8'hF4, 8'hC4, 8'hF4, 8'hDD,
        8'h5D, 8'hD0, 8'hDB, 8'h1F, 8'h00, 8'h00, 8'hC0, 8'hFF
    };

    // RAM model: sparse, all zero after reset, one-cycle read latency
    logic [7:0] mem [logic [15:0]];
    // Reference contents and mapping, per the requirements
    logic [7:0] refm [logic [15:0]];
    bit ref_unmap = 1'b0;

    function automatic logic [7:0] mem_get(input logic [15:0] a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    function automatic logic [7:0] ref_get(input logic [15:0] a);
        return refm.exists(a) ? refm[a] : 8'h00;
    endfunction

    function automatic logic [7:0] exp_byte(input logic [15:0] a);
        if (a >= 16'hFFC0 && !ref_unmap) return IMG[a - 16'hFFC0];
        return ref_get(a);
    endfunction

    always @(posedge clk) begin
        if (ram_re) ram_rdata <= mem_get(ram_addr);
        if (ram_we) mem[ram_addr] = ram_wdata;
    end

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d, input string req);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        #1;
        check({15'd0, ram_we}, {15'd0, (a < 16'hFFC0) || ref_unmap}, req);
        @(negedge clk);
        cpu_wr = 1'b0;
        if (a < 16'hFFC0 || ref_unmap) refm[a] = d;
        if (a == 16'h00F1) ref_unmap = d[7];
    endtask

    task automatic do_read(input logic [15:0] a, input string req);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1; cpu_wide = 1'b0;
        @(negedge clk);
        cpu_rd = 1'b0;
        check({15'd0, cpu_rvalid}, 16'd1, req);
        check(cpu_rdata, {8'h00, exp_byte(a)}, req);
    endtask

    task automatic do_word(input logic [15:0] a, input string req);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1; cpu_wide = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0; cpu_wide = 1'b0;
        check({14'd0, cpu_busy, cpu_rvalid}, 16'b10, "R7");
        check(ram_addr, a + 16'd1, "R8");
        @(negedge clk);
        check({15'd0, cpu_rvalid}, 16'd1, "R7");
        check(cpu_rdata, {exp_byte(a + 16'd1), exp_byte(a)}, req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6: idle and mapped after reset
        check({14'd0, cpu_busy, cpu_rvalid}, 16'd0, "R6");
        do_read(16'hFFC0, "R6");

        // R2: every window byte from the image
        for (int n = 0; n < 64; n++) do_read(16'hFFC0 + 16'(n), "R2");

        // R5: window writes dropped while mapped (ram_we checked in do_write)
        for (int n = 0; n < 64; n++) do_write(16'hFFC0 + 16'(n), 8'(n) ^ 8'hA5, "R5");

        // R4/R1: low-region sweep
        for (int i = 0; i < 255; i++) begin
            logic [15:0] a;
            a = 16'(i * 257);
            do_write(a, a[15:8] ^ a[7:0] ^ 8'h3C, "R4");
        end
        for (int i = 0; i < 255; i++) do_read(16'(i * 257), "R1");
        do_read(16'hFFBF, "R1");

        // R3/R10: unmap, control byte reads back
        do_write(16'h00F1, 8'h80, "R3");
        do_read(16'h00F1, "R10");
        // R5: window shows RAM untouched by earlier blocked writes
        for (int n = 0; n < 64; n++) do_read(16'hFFC0 + 16'(n), "R5");
        // R5: window writes land while unmapped
        for (int n = 0; n < 64; n++) do_write(16'hFFC0 + 16'(n), 8'(n * 3) ^ 8'h69, "R5");
        for (int n = 0; n < 64; n++) do_read(16'hFFC0 + 16'(n), "R3");

        // R3: remap, image visible again
        do_write(16'h00F1, 8'h7F, "R3");
        do_read(16'h00F1, "R10");
        for (int n = 0; n < 64; n += 7) do_read(16'hFFC0 + 16'(n), "R3");

        // R7/R8/R9: word reads
        do_write(16'h0000, 8'h3C, "R4");
        do_write(16'h1234, 8'h11, "R4");
        do_write(16'h1235, 8'hE2, "R4");
        do_word(16'h1234, "R7");
        do_word(16'hFFFF, "R8");
        do_word(16'hFFBF, "R9");
        do_word(16'hFFC0, "R2");
        do_write(16'h00F1, 8'h80, "R3");
        do_word(16'hFFFF, "R8");
        do_word(16'hFFBF, "R9");

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 200000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule